// File: doc/BRIEF.md
# CAN Nominal Bit Timer with Resynchronization

This block derives the nominal bit timing of a CAN node from the system clock. A prescaler divides the clock into time quanta, and a segment sequencer walks each bit through three parts. The sync segment always lasts one quantum. Phase segment 1 follows, and the bit is sampled at its end. Phase segment 2 comes last, and its end is the transmit point, where the next bit starts. The block issues a one-cycle strobe at the sample point and another at the transmit point.

While the node runs, the block watches the received bus level for a qualifying edge. An edge during phase segment 1 lengthens that segment, so the sample point moves later. An edge during phase segment 2 shortens that segment, so the transmit point moves earlier. In both cases the change is limited by a programmable jump width.

Timing fields are captured only while the standby flag is high. After standby the sequencer waits on an idle bus until the first qualifying edge, which hard-synchronizes it to the start of a bit.

Top module: `can_bit_timer`

## Requirements
- R1: During and right after reset, `phase` is 0 (idle) and both strobes are low.
- R2: `phase` encodes idle as 0, sync as 1, segment 1 as 2 and segment 2 as 3. In idle, a qualifying edge puts the block into sync in the next cycle. This is the hard synchronization. A falling level in idle has no effect.
- R3: Without resynchronization, a quantum is P = prescale+1 clocks. After a hard sync, `sample_pulse` is high in the single cycle P*(seg1+2) clocks after sync begins. `tx_pulse` is high in the single cycle P*(seg1+seg2+3) clocks after sync begins, which is the first cycle of the next sync segment. Every later bit repeats the same pattern.
- R4: The bus level is 1 for recessive and 0 for dominant. A qualifying edge is a 0-to-1 step of `rx_level` seen while `tx_level` is 0. An edge detected in quantum q (counted from 0) of segment 1 extends that segment by min(q+1, J) quanta, where J = jump+1.
- R5: An edge detected in quantum q of segment 2, when J is below the remaining quanta (seg2+1-q), shortens segment 2 by J quanta.
- R6: An edge in segment 2 for which J is at least the remaining quanta ends the bit at once. `tx_pulse` is raised in the next cycle, and a new bit starts there at its sync segment.
- R7: A rising `rx_level` that is detected while `tx_level` is 1 causes no adjustment.
- R8: Only the first qualifying edge in a bit can adjust timing. Later edges in the same bit are ignored.
- R9: A qualifying edge during the sync segment causes no adjustment.
- R10: The timing fields are captured only while `cfg_mode` is high, and standby holds the block in idle with both strobes low. Field changes while `cfg_mode` is low have no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | Standby flag; timing fields are captured while high |
| cfg_prescale | input | 10 | Quantum length minus one, in clocks |
| cfg_seg1 | input | 4 | Phase segment 1 length minus one, in quanta |
| cfg_seg2 | input | 3 | Phase segment 2 length minus one, in quanta |
| cfg_jump | input | 2 | Jump width minus one, in quanta |
| rx_level | input | 1 | Received bus level, 1 = recessive |
| tx_level | input | 1 | Level this node is transmitting, 1 = recessive |
| phase | output | 2 | Current segment: 0 idle, 1 sync, 2 segment 1, 3 segment 2 |
| sample_pulse | output | 1 | One-cycle strobe after the sample point |
| tx_pulse | output | 1 | One-cycle strobe at the transmit point |

## Verification
The assertions assume that `rx_level`, `tx_level` and the configuration inputs are already synchronous to `clk`. They also assume that the fields change only between bits or during standby. The bench meets both conditions by driving every input on the falling clock edge. It also holds the fields fixed through each measured bit, except for deliberate out-of-standby writes that must have no effect. The checker also relies on every segment lasting at least one full quantum. This keeps consecutive strobes of one kind apart, and the stimulus uses only field values that obey it.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRESC_W = 10,
  parameter int SEG1_W  = 4,
  parameter int SEG2_W  = 3,
  parameter int SJW_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mode,
  input  logic [PRESC_W-1:0] cfg_prescale,
  input  logic [SEG1_W-1:0]  cfg_seg1,
  input  logic [SEG2_W-1:0]  cfg_seg2,
  input  logic [SJW_W-1:0]   cfg_jump,
  input  logic               rx_level,
  input  logic               tx_level,
  output logic [1:0]         phase,
  output logic               sample_pulse,
  output logic               tx_pulse
);

  localparam int CW = ((SEG1_W > SJW_W) ? SEG1_W : SJW_W) + 2;
  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_SYNC = 2'd1;
  localparam logic [1:0] PH_SEG1 = 2'd2;
  localparam logic [1:0] PH_SEG2 = 2'd3;

  logic [PRESC_W-1:0] brp_r, presc;
  logic [SEG1_W-1:0]  ts1_r;
  logic [SEG2_W-1:0]  ts2_r;
  logic [SJW_W-1:0]   sjw_r;
  logic [CW-1:0]      qcnt, ext, shr;
  logic               rx_d, edge_seen;

  logic          tq_tick, edge_ok, edge_s1, edge_s2, cut_now;
  logic [CW-1:0] jump, s1_err, ext_req, ext_eff, s1_last, s2_rem, shr_eff, s2_last;

  assign tq_tick = (presc == brp_r);
  assign jump    = CW'(sjw_r) + CW'(1);
  assign edge_ok = rx_level & ~rx_d & ~tx_level & ~edge_seen;
  assign edge_s1 = edge_ok && (phase == PH_SEG1);
  assign edge_s2 = edge_ok && (phase == PH_SEG2);

  assign s1_err  = qcnt + CW'(1);
  assign ext_req = (s1_err < jump) ? s1_err : jump;
  assign ext_eff = edge_s1 ? ext_req : ext;
  assign s1_last = CW'(ts1_r) + ext_eff;

  assign s2_rem  = CW'(ts2_r) + CW'(1) - qcnt;
  assign cut_now = edge_s2 && (jump >= s2_rem);
  assign shr_eff = edge_s2 ? jump : shr;
  assign s2_last = CW'(ts2_r) - shr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brp_r        <= '0;
      ts1_r        <= '0;
      ts2_r        <= '0;
      sjw_r        <= '0;
      presc        <= '0;
      qcnt         <= '0;
      ext          <= '0;
      shr          <= '0;
      rx_d         <= 1'b1;
      edge_seen    <= 1'b0;
      phase        <= PH_IDLE;
      sample_pulse <= 1'b0;
      tx_pulse     <= 1'b0;
    end else begin
      rx_d         <= rx_level;
      sample_pulse <= 1'b0;
      tx_pulse     <= 1'b0;
      if (cfg_mode) begin
        brp_r     <= cfg_prescale;
        ts1_r     <= cfg_seg1;
        ts2_r     <= cfg_seg2;
        sjw_r     <= cfg_jump;
        phase     <= PH_IDLE;
        presc     <= '0;
        qcnt      <= '0;
        ext       <= '0;
        shr       <= '0;
        edge_seen <= 1'b0;
      end else if (phase == PH_IDLE) begin
        if (edge_ok) begin
          phase <= PH_SYNC;
          presc <= '0;
          qcnt  <= '0;
        end
      end else if (cut_now) begin
        phase     <= PH_SYNC;
        presc     <= '0;
        qcnt      <= '0;
        ext       <= '0;
        shr       <= '0;
        edge_seen <= 1'b0;
        tx_pulse  <= 1'b1;
      end else begin
        presc <= tq_tick ? '0 : presc + PRESC_W'(1);
        if (edge_ok) edge_seen <= 1'b1;
        if (edge_s1) ext <= ext_req;
        if (edge_s2) shr <= jump;
        if (tq_tick) begin
          case (phase)
            PH_SYNC: begin
              phase <= PH_SEG1;
              qcnt  <= '0;
            end
            PH_SEG1: begin
              if (qcnt == s1_last) begin
                phase        <= PH_SEG2;
                qcnt         <= '0;
                sample_pulse <= 1'b1;
              end else begin
                qcnt <= qcnt + CW'(1);
              end
            end
            default: begin
              if (qcnt == s2_last) begin
                phase     <= PH_SYNC;
                qcnt      <= '0;
                ext       <= '0;
                shr       <= '0;
                edge_seen <= 1'b0;
                tx_pulse  <= 1'b1;
              end else begin
                qcnt <= qcnt + CW'(1);
              end
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int PRESC_W = 10,
  parameter int SEG1_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_mode,
  input logic [1:0]         phase,
  input logic               sample_pulse,
  input logic               tx_pulse,
  input logic [PRESC_W-1:0] brp_q,
  input logic [SEG1_W-1:0]  ts1_q
);

  // R3
  sample_in_seg2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |-> phase == 2'd3);

  // R3
  sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |=> !sample_pulse);

  // R3
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse |=> !tx_pulse);

  // R6
  tx_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse |-> phase == 2'd1);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pulse && tx_pulse));

  // R10
  standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> (phase == 2'd0) && !sample_pulse && !tx_pulse);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(brp_q) && $stable(ts1_q));

endmodule

bind can_bit_timer can_bit_timer_chk #(.PRESC_W(PRESC_W), .SEG1_W(SEG1_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mode     (cfg_mode),
  .phase        (phase),
  .sample_pulse (sample_pulse),
  .tx_pulse     (tx_pulse),
  .brp_q        (brp_r),
  .ts1_q        (ts1_r)
);

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_mode = 1'b0;
  logic [9:0] cfg_prescale = '0;
  logic [3:0] cfg_seg1 = '0;
  logic [2:0] cfg_seg2 = '0;
  logic [1:0] cfg_jump = '0;
  logic       rx_level = 1'b1;
  logic       tx_level = 1'b0;
  logic [1:0] phase;
  logic       sample_pulse, tx_pulse;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_prescale(cfg_prescale), .cfg_seg1(cfg_seg1), .cfg_seg2(cfg_seg2),
    .cfg_jump(cfg_jump), .rx_level(rx_level), .tx_level(tx_level),
    .phase(phase), .sample_pulse(sample_pulse), .tx_pulse(tx_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // off: cycle (from sync start) where rx rises; off2: second rise; txl: tx_level at the rise
  task automatic run_case(input int brp, input int ts1, input int ts2, input int sjw,
                          input int off, input int off2, input bit txl, input bit junk,
                          input string req);
    int p, l1, l2, j, s0, t0, es, et, q, rem, s, t, sn;
    p = brp + 1; l1 = ts1 + 1; l2 = ts2 + 1; j = sjw + 1;
    s0 = p * (1 + l1); t0 = s0 + p * l2;
    es = s0; et = t0;
    if (off > 0 && !txl && off >= p) begin
      if (off < s0) begin
        q = (off - p) / p;
        es = s0 + p * (((q + 1) < j) ? (q + 1) : j);
        et = es + p * l2;
      end else begin
        q = (off - s0) / p;
        rem = l2 - q;
        et = (j >= rem) ? off + 1 : t0 - p * j;
      end
    end
    @(negedge clk);
    cfg_mode = 1'b1;
    cfg_prescale = 10'(brp); cfg_seg1 = 4'(ts1); cfg_seg2 = 3'(ts2); cfg_jump = 2'(sjw);
    rx_level = 1'b1; tx_level = 1'b0;
    repeat (2) @(negedge clk);
    cfg_mode = 1'b0;
    if (junk) begin
      cfg_prescale = 10'(brp + 2); cfg_seg1 = ~4'(ts1); cfg_seg2 = ~3'(ts2); cfg_jump = ~2'(sjw);
    end
    @(negedge clk);
    chk("R10 idle after standby", int'(phase), 0);
    rx_level = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 falling level in idle", int'(phase), 0);
    rx_level = 1'b1;
    @(negedge clk);
    chk("R2 hard sync enters sync", int'(phase), 1);
    s = -1; t = -1; sn = -1;
    for (int c = 0; c < 400 && sn < 0; c++) begin
      if (sample_pulse && s < 0) s = c;
      else if (sample_pulse && t >= 0 && sn < 0) sn = c;
      if (tx_pulse && t < 0) t = c;
      if (c == 0) rx_level = 1'b0;
      if (off > 0 && c == off) begin rx_level = 1'b1; tx_level = txl; end
      if (off > 0 && c == off + 1) begin
        tx_level = 1'b0;
        if (off2 > 0) rx_level = 1'b0;
      end
      if (off2 > 0 && c == off2) rx_level = 1'b1;
      @(negedge clk);
    end
    chk({req, " sample point"}, s, es);
    chk({req, " transmit point"}, t, et);
    chk("R3 next bit sample", sn, et + p * (1 + l1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset phase", int'(phase), 0);
    chk("R1 reset strobes", int'({sample_pulse, tx_pulse}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'({phase, sample_pulse, tx_pulse}), 0);

    // R3 / R10: nominal sweep, alternate cases write junk outside standby
    for (int b = 0; b < 3; b++)
      for (int a = 0; a < 3; a++)
        for (int d = 0; d < 3; d++)
          run_case(b, (a == 0) ? 0 : (a == 1) ? 3 : 15, (d == 0) ? 0 : (d == 1) ? 2 : 7,
                   d, 0, 0, 1'b0, 1'((a + d) % 2), (((a + d) % 2) != 0) ? "R10" : "R3");

    // R4 / R5 / R6: edge position sweep
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < 4; w++) begin
        int p, s0, t0;
        p = b + 1; s0 = p * 7; t0 = s0 + p * 5;
        for (int o = p; o < t0; o++) begin
          int q, rem;
          q = (o - s0) / p; rem = 5 - q;
          run_case(b, 5, 4, w, o, 0, 1'b0, 1'b0,
                   (o < s0) ? "R4" : ((w + 1 >= rem) ? "R6" : "R5"));
        end
      end

    // R7: edge while this node sends recessive
    run_case(1, 5, 4, 3, 6, 0, 1'b1, 1'b0, "R7 seg1");
    run_case(1, 5, 4, 3, 16, 0, 1'b1, 1'b0, "R7 seg2");
    // R8: second edge in the same bit is ignored
    run_case(0, 5, 4, 1, 2, 5, 1'b0, 1'b0, "R8 seg1 pair");
    run_case(1, 5, 4, 0, 4, 16, 1'b0, 1'b0, "R8 seg1 then seg2");
    // R9: edge in sync segment
    run_case(3, 3, 3, 3, 2, 0, 1'b0, 1'b0, "R9 sync edge");
    run_case(3, 3, 3, 3, 2, 8, 1'b0, 1'b0, "R9 sync edge blocks later");

    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule